// File: doc/BRIEF.md
# Reset-Time Read Protection Controller

This block decides, once per reset, whether the chip's stored program may be exposed to outside tools. Right after a hardware reset or a watchdog restart it fetches a single protection word from a synchronous flash read port at byte address 0x1FC. It compares that word with the magic value 0x87654321. It then sets the security permits that the rest of the chip obeys: a debug enable, a select that connects the shared debug pins to the JTAG port, a permit for booting from external memory, and a permit mask that the in-system-programming command decoder applies to its restricted commands.

Debug stays unable to act from reset until the word has been read and judged. Debug is granted only when the word does not hold the magic value. The controller fails closed: a flash error, or a read that does not answer within a programmable cycle count, leaves the part protected. A protected part returns the shared debug pins to GPIO even when the debug-select pin asked for JTAG. The decision holds until the next reset of either kind.

The sequence has four named states. IDLE is held during reset and lasts one clock after it. READ issues the flash request and waits. COMPARE judges the captured word. DONE is terminal and drives the permits. The transitions are: IDLE→READ (always); READ→COMPARE (data returned without error); READ→DONE (error response, or time limit reached with no response); COMPARE→DONE (always). Any state goes to IDLE on a watchdog restart.

Top module: `rdprot_ctrl`

## Requirements
- R1: While reset is asserted, dbg_enable, ext_boot_ok, chk_done, prot_active, jtag_pins_sel and fl_req are all 0, and isp_permit is 4'b0000.
- R2: In the first clock after reset release the block is in IDLE. In the next clock (READ) fl_req is 1 with fl_addr equal to byte address 0x1FC. fl_req stays 1 until a response is accepted or the time limit ends the read, and it is 0 in every other state.
- R3: If the returned word equals 0x87654321, then in DONE prot_active is 1, dbg_enable is 0, ext_boot_ok is 0 and isp_permit is 4'b0000.
- R4: Any other word returned without error gives, in DONE, prot_active 0, dbg_enable 1, ext_boot_ok 1 and isp_permit 4'b1111. The mask bit order is bit0 read-memory, bit1 write-to-RAM, bit2 go/execute, bit3 copy-RAM-to-flash. Commands outside the mask are never gated.
- R5: No permit is granted before chk_done rises. If fl_valid is accepted without error in READ cycle k (k=0 is the first READ cycle), chk_done rises k+3 clocks after reset release.
- R6: A response with fl_err high ends the read with protection active, and chk_done rises k+2 clocks after reset release.
- R7: A response is accepted in READ cycles 0 to tmo_limit, inclusive. If none arrives by then, the block enters DONE protected, and chk_done rises tmo_limit+2 clocks after reset release.
- R8: jtag_pins_sel is 1 only when dbg_sel_n was low on the first clock after reset release, pin_release is currently 0, and protection is not active. While pin_release is 1, the pins are GPIO.
- R9: When protection is active, jtag_pins_sel is 0 even if dbg_sel_n was sampled low.
- R10: Once in DONE, the decision and the permits do not change in response to further flash responses or to pin_release, until the next reset. dbg_enable never falls except through a reset.
- R11: A one-cycle wdt_rst pulse drops all permits and chk_done on the next clock, resamples dbg_sel_n, and reruns the full sequence with the same timing as a hardware reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| wdt_rst | input | 1 | Synchronous watchdog restart, active high |
| dbg_sel_n | input | 1 | Debug-select pin, low requests JTAG on the shared pins |
| pin_release | input | 1 | Software pin-select bit, 1 returns the shared pins to GPIO |
| tmo_limit | input | 8 | Last READ cycle index in which a flash response is accepted |
| fl_req | output | 1 | Flash read request |
| fl_addr | output | 12 | Flash byte address of the protection word |
| fl_valid | input | 1 | Flash read data valid |
| fl_err | input | 1 | Flash read error, qualified by fl_valid |
| fl_rdata | input | 32 | Flash read data |
| dbg_enable | output | 1 | Debug logic may act |
| jtag_pins_sel | output | 1 | 1 connects the shared pins to JTAG, 0 leaves them GPIO |
| ext_boot_ok | output | 1 | External memory boot permitted |
| isp_permit | output | 4 | Permit mask for the restricted in-system-programming commands |
| chk_done | output | 1 | Protection check finished (DONE state) |
| prot_active | output | 1 | Protection decided active |

## Verification
Two decisions can meet in the same READ cycle: a flash response can arrive in exactly the last cycle the time limit allows. The bench provokes this by setting the response latency equal to tmo_limit, and separately to tmo_limit plus one. The first must be judged by its data and reach DONE after tmo_limit+3 clocks. The second must fail closed after tmo_limit+2 clocks. A second collision puts a stray flash response, or a pin_release toggle, in the same clocks in which DONE is held. The permits must stay exactly as decided.

// File: rtl/rdprot_pkg.sv
`timescale 1ns/1ps
package rdprot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_CMP  = 2'd2,
        ST_DONE = 2'd3
    } rdprot_state_e;

    // Bit positions inside the command permit mask
    localparam int CMD_RDMEM  = 0;
    localparam int CMD_WRRAM  = 1;
    localparam int CMD_GO     = 2;
    localparam int CMD_COPY   = 3;
    localparam int CMD_COUNT  = 4;

endpackage

// File: rtl/rdprot_timer.sv
`timescale 1ns/1ps
module rdprot_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    localparam logic [TMO_W-1:0] CNT_MAX = '1;

    logic [TMO_W-1:0] cnt_q;

    // Counts READ cycles; value equals the current READ cycle index.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q >= limit);

endmodule

// File: rtl/rdprot_pinmux.sv
`timescale 1ns/1ps
module rdprot_pinmux (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic capture,
    input  logic dbg_sel_n,
    input  logic pin_release,
    input  logic locked,
    output logic jtag_sel
);
    logic want_jtag_q;

    // The pin level is latched once, in the IDLE clock that follows any reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            want_jtag_q <= 1'b0;
        end else if (restart) begin
            want_jtag_q <= 1'b0;
        end else if (capture) begin
            want_jtag_q <= ~dbg_sel_n;
        end
    end

    assign jtag_sel = want_jtag_q & ~pin_release & ~locked;

endmodule

// File: rtl/rdprot_fsm.sv
`timescale 1ns/1ps
module rdprot_fsm
    import rdprot_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          DATA_W    = 32,
    parameter int          CMD_W     = CMD_COUNT,
    parameter logic [ADDR_W-1:0] WORD_ADDR = 12'h1FC,
    parameter logic [DATA_W-1:0] MAGIC     = 32'h8765_4321
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              fl_valid,
    input  logic              fl_err,
    input  logic [DATA_W-1:0] fl_rdata,
    input  logic              expired,
    output rdprot_state_e     state_o,
    output logic              fl_req,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              dbg_en,
    output logic              ext_boot,
    output logic [CMD_W-1:0]  isp_mask,
    output logic              done,
    output logic              locked
);
    rdprot_state_e     state_q, state_d;
    logic [DATA_W-1:0] word_q;
    logic              prot_q;
    logic              open_grant;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_READ;
                ST_READ: begin
                    if (fl_valid) begin
                        state_d = fl_err ? ST_DONE : ST_CMP;
                    end else if (expired) begin
                        state_d = ST_DONE;
                    end
                end
                ST_CMP:  state_d = ST_DONE;
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Word capture and decision; protection defaults on (fail closed)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            prot_q <= 1'b1;
        end else if (restart) begin
            word_q <= '0;
            prot_q <= 1'b1;
        end else begin
            if ((state_q == ST_READ) && fl_valid && !fl_err) begin
                word_q <= fl_rdata;
            end
            if (state_q == ST_CMP) begin
                prot_q <= (word_q == MAGIC);
            end
        end
    end

    // Outputs
    always_comb begin
        fl_req     = 1'b0;
        fl_addr    = '0;
        done       = 1'b0;
        locked     = 1'b0;
        open_grant = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ: begin
                fl_req  = 1'b1;
                fl_addr = WORD_ADDR;
            end
            ST_CMP: ;
            ST_DONE: begin
                done       = 1'b1;
                locked     = prot_q;
                open_grant = ~prot_q;
            end
            default: ;
        endcase
    end

    assign dbg_en   = open_grant;
    assign ext_boot = open_grant;
    assign state_o  = state_q;

    for (genvar i = 0; i < CMD_W; i++) begin : g_mask
        assign isp_mask[i] = open_grant;
    end

endmodule

// File: rtl/rdprot_ctrl.sv
`timescale 1ns/1ps
module rdprot_ctrl
    import rdprot_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int TMO_W  = 8,
    parameter logic [ADDR_W-1:0] WORD_ADDR = 12'h1FC,
    parameter logic [DATA_W-1:0] MAGIC     = 32'h8765_4321
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wdt_rst,
    input  logic                 dbg_sel_n,
    input  logic                 pin_release,
    input  logic [TMO_W-1:0]     tmo_limit,
    output logic                 fl_req,
    output logic [ADDR_W-1:0]    fl_addr,
    input  logic                 fl_valid,
    input  logic                 fl_err,
    input  logic [DATA_W-1:0]    fl_rdata,
    output logic                 dbg_enable,
    output logic                 jtag_pins_sel,
    output logic                 ext_boot_ok,
    output logic [CMD_COUNT-1:0] isp_permit,
    output logic                 chk_done,
    output logic                 prot_active
);
    rdprot_state_e state;
    logic          expired;

    rdprot_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CMD_W    (CMD_COUNT),
        .WORD_ADDR(WORD_ADDR),
        .MAGIC    (MAGIC)
    ) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wdt_rst),
        .fl_valid(fl_valid),
        .fl_err  (fl_err),
        .fl_rdata(fl_rdata),
        .expired (expired),
        .state_o (state),
        .fl_req  (fl_req),
        .fl_addr (fl_addr),
        .dbg_en  (dbg_enable),
        .ext_boot(ext_boot_ok),
        .isp_mask(isp_permit),
        .done    (chk_done),
        .locked  (prot_active)
    );

    rdprot_timer #(.TMO_W(TMO_W)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state != ST_READ),
        .run    (state == ST_READ),
        .limit  (tmo_limit),
        .expired(expired)
    );

    rdprot_pinmux pinmux_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (wdt_rst),
        .capture    (state == ST_IDLE),
        .dbg_sel_n  (dbg_sel_n),
        .pin_release(pin_release),
        .locked     (prot_active),
        .jtag_sel   (jtag_pins_sel)
    );

endmodule

// File: rtl/rdprot_ctrl_chk.sv
`timescale 1ns/1ps
module rdprot_ctrl_chk #(
    parameter int CMD_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wdt_rst,
    input logic             pin_release,
    input logic             fl_req,
    input logic             dbg_enable,
    input logic             jtag_pins_sel,
    input logic             ext_boot_ok,
    input logic [CMD_W-1:0] isp_permit,
    input logic             chk_done,
    input logic             prot_active
);
    assert_nogrant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_done |-> (!dbg_enable && !ext_boot_ok && (isp_permit == '0)));

    assert_lockout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prot_active |-> (!dbg_enable && !ext_boot_ok && (isp_permit == '0)));

    assert_gpio_R9: assert property (@(posedge clk) disable iff (!rst_n)
        prot_active |-> !jtag_pins_sel);

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pin_release |-> !jtag_pins_sel);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_done && !wdt_rst) |=> (chk_done && (prot_active == $past(prot_active))));

    assert_norevoke_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dbg_enable) |-> $past(wdt_rst));

    assert_readwin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> !chk_done);

    assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> (!chk_done && !dbg_enable));

endmodule

bind rdprot_ctrl rdprot_ctrl_chk #(.CMD_W(rdprot_pkg::CMD_COUNT)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wdt_rst      (wdt_rst),
    .pin_release  (pin_release),
    .fl_req       (fl_req),
    .dbg_enable   (dbg_enable),
    .jtag_pins_sel(jtag_pins_sel),
    .ext_boot_ok  (ext_boot_ok),
    .isp_permit   (isp_permit),
    .chk_done     (chk_done),
    .prot_active  (prot_active)
);

// File: tb/rdprot_ctrl_tb_top.sv
`timescale 1ns/1ps
module rdprot_ctrl_tb_top;

    localparam logic [31:0] MAGIC_W = 32'h8765_4321;
    localparam logic [11:0] ADDR_W  = 12'h1FC;
    localparam int NV = 10;

    // Stimulus table: word, error flag, response latency, limit, pin level, release
    localparam logic [31:0] V_WORD [NV] = '{32'h8765_4321, 32'h0000_0000, 32'h8765_4320,
                                            32'hFFFF_FFFF, 32'h8765_4321, 32'h1234_5678,
                                            32'h1234_5678, 32'h1234_5678, 32'h1234_5678,
                                            32'h1234_5678};
    localparam bit V_ERR [NV] = '{0, 0, 0, 0, 0, 1, 0, 0, 0, 0};
    localparam int V_LAT [NV] = '{2, 0, 3, 5, 1, 2, 10, 11, 0, 200};
    localparam int V_TMO [NV] = '{10, 10, 10, 10, 10, 10, 10, 10, 0, 4};
    localparam bit V_DSN [NV] = '{1, 0, 0, 1, 0, 0, 0, 0, 0, 0};
    localparam bit V_REL [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wdt_rst = 1'b0;
    logic        dbg_sel_n = 1'b1;
    logic        pin_release = 1'b0;
    logic [7:0]  tmo_limit = 8'd10;
    logic        fl_req;
    logic [11:0] fl_addr;
    logic        fl_valid;
    logic        fl_err;
    logic [31:0] fl_rdata;
    logic        dbg_enable, jtag_pins_sel, ext_boot_ok, chk_done, prot_active;
    logic [3:0]  isp_permit;

    logic [31:0] cur_word = '0;
    logic        cur_err = 1'b0;
    int          cur_lat = 0;
    int          req_cnt = 0;
    logic        mdl_valid = 1'b0;
    logic        inj_valid = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign fl_valid = mdl_valid | inj_valid;
    assign fl_err   = cur_err;
    assign fl_rdata = cur_word;

    // Flash model: answers in READ cycle cur_lat of an outstanding request
    always @(negedge clk) begin
        if (fl_req) begin
            mdl_valid <= (req_cnt == cur_lat);
            req_cnt   <= req_cnt + 1;
        end else begin
            mdl_valid <= 1'b0;
            req_cnt   <= 0;
        end
    end

    rdprot_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .dbg_sel_n(dbg_sel_n),
        .pin_release(pin_release), .tmo_limit(tmo_limit),
        .fl_req(fl_req), .fl_addr(fl_addr), .fl_valid(fl_valid), .fl_err(fl_err),
        .fl_rdata(fl_rdata), .dbg_enable(dbg_enable), .jtag_pins_sel(jtag_pins_sel),
        .ext_boot_ok(ext_boot_ok), .isp_permit(isp_permit), .chk_done(chk_done),
        .prot_active(prot_active)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Counts clocks from a reset release until chk_done; checks R2 and R5 along the way
    task automatic wait_done(output int n);
        bit leak = 0;
        bit req_ok = 0;
        n = 0;
        while (n < 400) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 1) req_ok = fl_req && (fl_addr == ADDR_W);
            if (chk_done) break;
            if (dbg_enable || ext_boot_ok || (isp_permit != 4'b0000)) leak = 1;
        end
        check(req_ok, "R2", "read request/address in first READ cycle", {fl_req, fl_addr}, {1'b1, ADDR_W});
        check(!leak, "R5", "no permit before done", leak, 0);
    endtask

    task automatic check_decision(input bit exp_prot, input bit exp_jtag);
        string rq;
        rq = exp_prot ? "R3" : "R4";
        check(prot_active == exp_prot, rq, "prot_active", prot_active, exp_prot);
        check(dbg_enable == !exp_prot, rq, "dbg_enable", dbg_enable, !exp_prot);
        check(ext_boot_ok == !exp_prot, rq, "ext_boot_ok", ext_boot_ok, !exp_prot);
        check(isp_permit == (exp_prot ? 4'b0000 : 4'b1111), rq, "isp_permit",
              isp_permit, exp_prot ? 4'b0000 : 4'b1111);
        check(jtag_pins_sel == exp_jtag, exp_prot ? "R9" : "R8", "jtag_pins_sel",
              jtag_pins_sel, exp_jtag);
    endtask

    task automatic run_vec(input int i);
        int  n;
        bit  tmo_hit, exp_prot, exp_jtag;
        int  exp_n;
        string rq;
        cur_word    = V_WORD[i];
        cur_err     = V_ERR[i];
        cur_lat     = V_LAT[i];
        tmo_limit   = 8'(V_TMO[i]);
        dbg_sel_n   = V_DSN[i];
        pin_release = V_REL[i];
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        tmo_hit  = V_LAT[i] > V_TMO[i];
        exp_prot = tmo_hit || V_ERR[i] || (V_WORD[i] == MAGIC_W);
        exp_jtag = !V_DSN[i] && !V_REL[i] && !exp_prot;
        if (tmo_hit) begin exp_n = V_TMO[i] + 2; rq = "R7"; end
        else if (V_ERR[i]) begin exp_n = V_LAT[i] + 2; rq = "R6"; end
        else begin exp_n = V_LAT[i] + 3; rq = "R5"; end
        wait_done(n);
        check(n == exp_n, rq, $sformatf("vector %0d done latency", i), n, exp_n);
        check_decision(exp_prot, exp_jtag);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL R5 watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int n;
        // R1: reset state
        repeat (2) @(negedge clk);
        check(!dbg_enable && !ext_boot_ok && !chk_done && !prot_active && !jtag_pins_sel
              && !fl_req && (isp_permit == 4'b0000), "R1", "outputs in reset",
              {dbg_enable, ext_boot_ok, chk_done, prot_active, jtag_pins_sel, fl_req, isp_permit}, 0);

        // Table walk
        for (int i = 0; i < NV; i++) run_vec(i);

        // R8: pin release after an open decision with JTAG requested
        cur_word = 32'h0; cur_err = 0; cur_lat = 1; tmo_limit = 8'd10;
        dbg_sel_n = 1'b0; pin_release = 1'b0;
        rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
        wait_done(n);
        check(jtag_pins_sel == 1'b1, "R8", "JTAG connected before release", jtag_pins_sel, 1);
        pin_release = 1'b1;
        @(negedge clk);
        check(jtag_pins_sel == 1'b0, "R8", "GPIO while released", jtag_pins_sel, 0);
        check(dbg_enable == 1'b1, "R10", "debug kept across release", dbg_enable, 1);
        pin_release = 1'b0;
        @(negedge clk);
        check(jtag_pins_sel == 1'b1, "R8", "JTAG back after release cleared", jtag_pins_sel, 1);

        // R10: stray flash responses in DONE change nothing
        cur_word = MAGIC_W; inj_valid = 1'b1;
        @(negedge clk);
        cur_err = 1'b1;
        @(negedge clk);
        inj_valid = 1'b0; cur_err = 1'b0;
        @(negedge clk);
        check(chk_done && !prot_active && dbg_enable && (isp_permit == 4'b1111), "R10",
              "decision after stray responses", {chk_done, prot_active, dbg_enable, isp_permit},
              {1'b1, 1'b0, 1'b1, 4'b1111});

        // R11: watchdog restart reruns the check, now finding the magic word
        cur_lat = 2;
        wdt_rst = 1'b1;
        @(negedge clk);
        wdt_rst = 1'b0;
        check(!chk_done && !dbg_enable && !jtag_pins_sel && (isp_permit == 4'b0000), "R11",
              "permits dropped after restart", {chk_done, dbg_enable, jtag_pins_sel, isp_permit}, 0);
        wait_done(n);
        check(n == 5, "R11", "restart done latency", n, 5);
        check_decision(1'b1, 1'b0);

        // R11: second restart with open word and pin now high (resampled)
        cur_word = 32'h0000_1111; dbg_sel_n = 1'b1; cur_lat = 0;
        wdt_rst = 1'b1;
        @(negedge clk);
        wdt_rst = 1'b0;
        check(!chk_done && !prot_active, "R11", "state cleared by restart",
              {chk_done, prot_active}, 0);
        wait_done(n);
        check(n == 3, "R11", "second restart done latency", n, 3);
        check_decision(1'b0, 1'b0);

        finish_run();
    end

endmodule